// File: doc/BRIEF.md
# SD Data FIFO Byte Pump

This block moves data between a 32-bit host data port and a byte-wide card data port. A sixteen-word circular FIFO sits between them. Loading the block count starts a transfer whose length is the block count times the block size. In the read direction, card bytes are packed into words and pushed into the FIFO for the host to drain. In the write direction, the host fills the FIFO and the pump unpacks each word onto the card port, one byte at a time.

The pump sets sticky status flags for every word it moves and for each block boundary on writes. It also keeps a debug word that shows the live FIFO level and marks the transfer as back in data mode when the byte count runs out. Command issue and CRC handling belong to neighbouring logic, which drives the direction inputs and the register strobes.

Top module: `sd_byte_pump`

## Requirements
- R1: The FIFO holds 16 words and returns host pushes in order. A host push while 16 words are held is dropped and leaves the level at 16. A host push in the same cycle as a pump push is dropped.
- R2: A host read with the FIFO empty returns 0 on `hostRdData` and leaves the level at 0.
- R3: A strobe on `blkCountWrEn` loads the remaining byte count with `blkCountData` times the stored block size. Exactly that many bytes are then moved, and after that the card handshake outputs stay low.
- R4: On reads, the first card byte lands in bits 7:0 of a word and each later byte lands one lane higher. A word is pushed once its fourth byte arrives.
- R5: On reads, when the remaining count reaches zero with fewer than four bytes gathered, the partial word is pushed with its unused upper lanes set to zero.
- R6: On reads, `cardRxReady` is high only while bytes remain and the FIFO holds fewer than 16 words. A full FIFO stalls the read.
- R7: On writes, a word is popped and sent out least significant byte first, one byte per handshake. `cardTxValid` stays low while the FIFO is empty and no bytes of a popped word remain.
- R8: Each word the pump moves sets `statusBits[0]`. It also sets `statusBits[8]` when `cfgDataIrqEn` is high. Writing ones through `statusClrMask` with `statusClrEn` clears those bits. In the same cycle, a set wins over a clear.
- R9: On writes only, `statusBits[9]` is set when the remaining count falls to a multiple of the block size and `cfgBlkIrqEn` is high.
- R10: The byte that takes the remaining count to zero sets `dbgWord[3:0]` to 1.
- R11: `dbgWord[8:4]` always equals the current FIFO level, and the level moves by at most one word per cycle.
- R12: `dbgWord` resets to 0x0000C60F. A `dbgWrEn` write stores `dbgWrData` in every bit outside 8:4, except that a value of 0xF in bits 3:0 is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host data write strobe (FIFO push) |
| hostWrData | input | 32 | Host data written to the FIFO |
| hostRdEn | input | 1 | Host data read strobe (FIFO pop) |
| hostRdData | output | 32 | FIFO head word, 0 when empty |
| xferRead | input | 1 | Card-to-host direction selected (wins over write) |
| xferWrite | input | 1 | Host-to-card direction selected |
| cfgDataIrqEn | input | 1 | Enables status bit 8 on word moves |
| cfgBlkIrqEn | input | 1 | Enables status bit 9 on write block boundaries |
| blkSizeWrEn | input | 1 | Block size register write strobe |
| blkSizeData | input | 12 | Block size in bytes |
| blkCountWrEn | input | 1 | Block count write strobe, starts a transfer |
| blkCountData | input | 9 | Number of blocks |
| statusClrEn | input | 1 | Status clear strobe |
| statusClrMask | input | 10 | Ones clear the matching status bits |
| statusBits | output | 10 | Sticky status: bit 0 data, bit 8 data interrupt, bit 9 block interrupt |
| dbgWrEn | input | 1 | Debug word write strobe |
| dbgWrData | input | 32 | Debug word write value |
| dbgWord | output | 32 | Debug word: 8:4 FIFO level, 3:0 transfer state |
| cardRxValid | input | 1 | Card has a byte available |
| cardRxData | input | 8 | Byte from the card |
| cardRxReady | output | 1 | Pump accepts a card byte |
| cardTxValid | output | 1 | Pump offers a byte to the card |
| cardTxData | output | 8 | Byte to the card |
| cardTxReady | input | 1 | Card accepts the byte |

## Verification
The read path is tried with several transfers. A six-byte transfer separates full-word packing from the zero-padded tail. An eighty-byte transfer overruns the FIFO, which shows the stall and then the ordering when refill is interleaved with draining. The write path is tried first with the FIFO empty after the count is loaded, which proves it waits rather than sending stale data. It is then tried with two distinct words, which exposes the byte order and the block-boundary flag, and again with both interrupt enables off. A plain push-and-drain run past capacity separates the drop-when-full rule from the return-zero-when-empty rule.

// File: rtl/sd_pump_pkg.sv
package sd_pump_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;

  // strobes from the control to the FIFO datapath
  typedef struct packed {
    logic              push;
    logic              pop;
    logic [WORD_W-1:0] pushWord;
  } fifoCmd_t;
endpackage

// File: rtl/sd_pump_fifo.sv
module sd_pump_fifo
  import sd_pump_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoCmd_t          cmd,
  output logic [WORD_W-1:0] headWord,
  output logic [CW-1:0]     occupancy,
  output logic              isFull,
  output logic              isEmpty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rdPtr, wrPtr;
  logic              doPush, doPop;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign isFull   = (occupancy == CW'(DEPTH));
  assign isEmpty  = (occupancy == '0);
  assign doPush   = cmd.push & ~isFull;
  assign doPop    = cmd.pop & ~isEmpty;
  assign headWord = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cmd.pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (doPush) wrPtr <= advance(wrPtr);
      if (doPop)  rdPtr <= advance(rdPtr);
      case ({doPush, doPop})
        2'b10:   occupancy <= occupancy + CW'(1);
        2'b01:   occupancy <= occupancy - CW'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end
endmodule

// File: rtl/sd_pump_ctrl.sv
module sd_pump_ctrl
  import sd_pump_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 12,
  parameter int BLKS_W = 9,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int REM_W = SIZE_W + BLKS_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              xferRead,
  input  logic              xferWrite,
  input  logic              cfgDataIrqEn,
  input  logic              cfgBlkIrqEn,
  input  logic              blkSizeWrEn,
  input  logic [SIZE_W-1:0] blkSizeData,
  input  logic              blkCountWrEn,
  input  logic [BLKS_W-1:0] blkCountData,
  input  logic              statusClrEn,
  input  logic [9:0]        statusClrMask,
  output logic [9:0]        statusBits,
  input  logic              dbgWrEn,
  input  logic [31:0]       dbgWrData,
  output logic [31:0]       dbgWord,
  input  logic              cardRxValid,
  input  logic [BYTE_W-1:0] cardRxData,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [BYTE_W-1:0] cardTxData,
  input  logic              cardTxReady,
  output fifoCmd_t          fifoCmd,
  input  logic [WORD_W-1:0] headWord,
  input  logic [CW-1:0]     occupancy,
  input  logic              isFull,
  input  logic              isEmpty
);
  localparam logic [31:0] DBG_RESET = 32'h0000_C60F;
  localparam logic [31:0] LEVEL_MSK = 32'h0000_01F0;
  localparam logic [3:0]  STATE_DATA = 4'h1;
  localparam logic [3:0]  STATE_OFF  = 4'hF;

  logic [SIZE_W-1:0] blkSize, blkLeft;
  logic [REM_W-1:0]  remCnt;
  logic [WORD_W-1:0] packAcc, rxWord, txWord;
  logic [IDX_W-1:0]  packIdx, txLeft;
  logic [9:0]        status, statusNext;
  logic [31:0]       dbgStore, dbgNext;
  logic              rdMode, wrMode, active, lastByte;
  logic              rxTake, rxWordDone, txTake, txFetch, byteTake, blkEdge, wordMoved;
  logic [4:0]        levelField;

  assign rdMode   = xferRead;
  assign wrMode   = xferWrite & ~xferRead;
  assign active   = (remCnt != '0);
  assign lastByte = (remCnt == REM_W'(1));

  // read direction: pack card bytes little-endian
  assign cardRxReady = rdMode & active & ~isFull;
  assign rxTake      = cardRxReady & cardRxValid;
  assign rxWordDone  = rxTake & ((packIdx == IDX_W'(LANES - 1)) | lastByte);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign rxWord[b*BYTE_W +: BYTE_W] =
      (packIdx == IDX_W'(b)) ? cardRxData : packAcc[b*BYTE_W +: BYTE_W];
  end

  // write direction: unpack words least significant byte first
  assign cardTxValid = wrMode & active & ((txLeft != '0) | ~isEmpty);
  assign cardTxData  = (txLeft != '0) ? txWord[BYTE_W-1:0] : headWord[BYTE_W-1:0];
  assign txTake      = cardTxValid & cardTxReady;
  assign txFetch     = txTake & (txLeft == '0);

  assign byteTake  = rxTake | txTake;
  assign blkEdge   = txTake & (blkLeft == SIZE_W'(1));
  assign wordMoved = rxWordDone | txFetch;

  // FIFO strobes: the pump has priority over the host on both ports
  always_comb begin
    fifoCmd.push     = rxWordDone | hostWrEn;
    fifoCmd.pushWord = rxWordDone ? rxWord : hostWrData;
    fifoCmd.pop      = txFetch | hostRdEn;
  end
  assign hostRdData = isEmpty ? '0 : headWord;

  always_comb begin
    statusNext = statusClrEn ? (status & ~statusClrMask) : status;
    if (wordMoved) begin
      statusNext[0] = 1'b1;
      if (cfgDataIrqEn) statusNext[8] = 1'b1;
    end
    if (blkEdge && cfgBlkIrqEn) statusNext[9] = 1'b1;
  end

  always_comb begin
    dbgNext = dbgStore;
    if (dbgWrEn) begin
      dbgNext = dbgWrData;
      if (dbgWrData[3:0] == STATE_OFF) dbgNext[3:0] = 4'h0;
    end
    if (byteTake && lastByte) dbgNext[3:0] = STATE_DATA;
  end

  assign levelField = 5'(occupancy);
  assign statusBits = status;
  assign dbgWord    = (dbgStore & ~LEVEL_MSK) | {23'd0, levelField, 4'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blkSize  <= '0;
      blkLeft  <= '0;
      remCnt   <= '0;
      packAcc  <= '0;
      packIdx  <= '0;
      txWord   <= '0;
      txLeft   <= '0;
      status   <= '0;
      dbgStore <= DBG_RESET;
    end else begin
      status   <= statusNext;
      dbgStore <= dbgNext;
      if (blkSizeWrEn) blkSize <= blkSizeData;
      if (blkCountWrEn) begin
        remCnt  <= REM_W'(blkCountData) * REM_W'(blkSize);
        blkLeft <= blkSize;
        packAcc <= '0;
        packIdx <= '0;
        txLeft  <= '0;
      end else if (byteTake) begin
        remCnt  <= remCnt - REM_W'(1);
        blkLeft <= (blkLeft == SIZE_W'(1)) ? blkSize : blkLeft - SIZE_W'(1);
        if (rxTake) begin
          if (rxWordDone) begin
            packAcc <= '0;
            packIdx <= '0;
          end else begin
            packAcc <= rxWord;
            packIdx <= packIdx + IDX_W'(1);
          end
        end
        if (txTake) begin
          if (txLeft == '0) begin
            txWord <= headWord >> BYTE_W;
            txLeft <= IDX_W'(LANES - 1);
          end else begin
            txWord <= txWord >> BYTE_W;
            txLeft <= txLeft - IDX_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sd_byte_pump.sv
module sd_byte_pump
  import sd_pump_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 12,
  parameter int BLKS_W = 9,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic [31:0]       hostWrData,
  input  logic              hostRdEn,
  output logic [31:0]       hostRdData,
  input  logic              xferRead,
  input  logic              xferWrite,
  input  logic              cfgDataIrqEn,
  input  logic              cfgBlkIrqEn,
  input  logic              blkSizeWrEn,
  input  logic [SIZE_W-1:0] blkSizeData,
  input  logic              blkCountWrEn,
  input  logic [BLKS_W-1:0] blkCountData,
  input  logic              statusClrEn,
  input  logic [9:0]        statusClrMask,
  output logic [9:0]        statusBits,
  input  logic              dbgWrEn,
  input  logic [31:0]       dbgWrData,
  output logic [31:0]       dbgWord,
  input  logic              cardRxValid,
  input  logic [7:0]        cardRxData,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [7:0]        cardTxData,
  input  logic              cardTxReady
);
  fifoCmd_t          fifoCmd;
  logic [WORD_W-1:0] headWord;
  logic [CW-1:0]     occupancy;
  logic              isFull, isEmpty;

  sd_pump_ctrl #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .BLKS_W(BLKS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .xferRead(xferRead), .xferWrite(xferWrite),
    .cfgDataIrqEn(cfgDataIrqEn), .cfgBlkIrqEn(cfgBlkIrqEn),
    .blkSizeWrEn(blkSizeWrEn), .blkSizeData(blkSizeData),
    .blkCountWrEn(blkCountWrEn), .blkCountData(blkCountData),
    .statusClrEn(statusClrEn), .statusClrMask(statusClrMask), .statusBits(statusBits),
    .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData), .dbgWord(dbgWord),
    .cardRxValid(cardRxValid), .cardRxData(cardRxData), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxData(cardTxData), .cardTxReady(cardTxReady),
    .fifoCmd(fifoCmd), .headWord(headWord), .occupancy(occupancy),
    .isFull(isFull), .isEmpty(isEmpty)
  );

  sd_pump_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .cmd(fifoCmd),
    .headWord(headWord), .occupancy(occupancy),
    .isFull(isFull), .isEmpty(isEmpty)
  );
endmodule

// File: rtl/sd_pump_chk.sv
module sd_pump_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cardRxReady,
  input logic        cardTxValid,
  input logic        cardTxReady,
  input logic [9:0]  statusBits,
  input logic [31:0] dbgWord,
  input logic [31:0] hostRdData,
  input logic        dbgWrEn,
  input logic        cmdPush,
  input logic        cmdPop
);
  logic [4:0] level;
  assign level = dbgWord[8:4];

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  p_empty_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 5'd0) |-> (hostRdData == 32'd0));

  p_one_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cardRxReady && cardTxValid));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cardRxReady |-> (32'(level) < DEPTH));

  p_word_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusBits[0]) |-> $past(cmdPush || cmdPop));

  p_block_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusBits[9]) |-> $past(cardTxValid && cardTxReady));

  p_level_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + 5'd1) || (level + 5'd1 == $past(level)));

  p_no_off_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbgWrEn) |-> (dbgWord[3:0] != 4'hF));
endmodule

bind sd_byte_pump sd_pump_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cardRxReady(cardRxReady), .cardTxValid(cardTxValid), .cardTxReady(cardTxReady),
  .statusBits(statusBits), .dbgWord(dbgWord), .hostRdData(hostRdData),
  .dbgWrEn(dbgWrEn), .cmdPush(fifoCmd.push), .cmdPop(fifoCmd.pop)
);

// File: tb/sd_byte_pump_tb.sv
module sd_byte_pump_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic        xferRead = 1'b0, xferWrite = 1'b0;
  logic        cfgDataIrqEn = 1'b0, cfgBlkIrqEn = 1'b0;
  logic        blkSizeWrEn = 1'b0, blkCountWrEn = 1'b0;
  logic [11:0] blkSizeData = '0;
  logic [8:0]  blkCountData = '0;
  logic        statusClrEn = 1'b0;
  logic [9:0]  statusClrMask = '0, statusBits;
  logic        dbgWrEn = 1'b0;
  logic [31:0] dbgWrData = '0, dbgWord;
  logic        cardRxValid = 1'b0, cardRxReady;
  logic [7:0]  cardRxData = '0, cardTxData;
  logic        cardTxValid, cardTxReady = 1'b0;

  always #2.5 clk = ~clk;

  sd_byte_pump u_dut (.*);

  int nChecks = 0, nFails = 0, cycles = 0;

  // behavioural reference state
  logic [31:0] q[$];
  logic [7:0]  rxSrc[$];
  logic [7:0]  txLog[$];
  int          mRem, mBlkSize, mBlkLeft, mIdx, mTxLeft, occ;
  logic [31:0] mAcc, mTxWord, mDbg, w, pushWord;
  logic [9:0]  mStatus, newSt;
  logic        rxT, txT, pumpPush, pumpPop, hostPop;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nFails++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000", cycles);
      finishUp();
    end
  end

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mRem = 0; mBlkSize = 0; mBlkLeft = 0; mIdx = 0; mTxLeft = 0;
      mAcc = '0; mTxWord = '0; mStatus = '0; mDbg = 32'h0000C60F;
      cardRxValid <= 1'b0;
    end else begin
      occ = q.size();
      rxT = xferRead && mRem != 0 && occ < DEPTH && cardRxValid;
      txT = xferWrite && !xferRead && mRem != 0 && (mTxLeft != 0 || occ != 0) && cardTxReady;
      pumpPush = 1'b0; pumpPop = 1'b0;
      newSt = statusClrEn ? (mStatus & ~statusClrMask) : mStatus;
      if (dbgWrEn) mDbg = (dbgWrData[3:0] == 4'hF) ? {dbgWrData[31:4], 4'h0} : dbgWrData;
      if (txT) txLog.push_back(cardTxData);
      if (rxT) begin
        w = mAcc | (32'(cardRxData) << (8 * mIdx));
        if (mIdx == 3 || mRem == 1) begin pumpPush = 1'b1; pushWord = w; mAcc = '0; mIdx = 0; end
        else begin mAcc = w; mIdx++; end
      end
      if (txT) begin
        if (mTxLeft == 0) begin pumpPop = 1'b1; mTxWord = q[0] >> 8; mTxLeft = 3; end
        else begin mTxWord = mTxWord >> 8; mTxLeft--; end
        if (mBlkLeft == 1 && cfgBlkIrqEn) newSt[9] = 1'b1;
      end
      if (rxT || txT) begin
        if (mRem == 1) mDbg[3:0] = 4'h1;
        mBlkLeft = (mBlkLeft == 1) ? mBlkSize : mBlkLeft - 1;
        mRem--;
      end
      if (pumpPush || pumpPop) begin
        newSt[0] = 1'b1;
        if (cfgDataIrqEn) newSt[8] = 1'b1;
      end
      hostPop = hostRdEn && occ != 0 && !pumpPop;
      if (pumpPop || hostPop) void'(q.pop_front());
      if (occ < DEPTH) begin
        if (pumpPush) q.push_back(pushWord);
        else if (hostWrEn) q.push_back(hostWrData);
      end
      if (blkCountWrEn) begin
        mRem = blkCountData * mBlkSize; mBlkLeft = mBlkSize; mIdx = 0; mAcc = '0; mTxLeft = 0;
      end
      if (blkSizeWrEn) mBlkSize = blkSizeData;
      mStatus = newSt;
      if (rxT) void'(rxSrc.pop_front());
      cardRxValid <= (rxSrc.size() != 0);
      cardRxData  <= (rxSrc.size() != 0) ? rxSrc[0] : 8'h00;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 rx ready", 32'(cardRxReady), 32'(xferRead && mRem != 0 && q.size() < DEPTH));
      chk("R7 tx valid", 32'(cardTxValid),
          32'(xferWrite && !xferRead && mRem != 0 && (mTxLeft != 0 || q.size() != 0)));
      if (cardTxValid)
        chk("R7 tx byte", 32'(cardTxData), (mTxLeft != 0) ? 32'(mTxWord[7:0]) : 32'(q[0][7:0]));
      chk("R1 head word", hostRdData, (q.size() != 0) ? q[0] : 32'h0);
      chk("R8 status", 32'(statusBits), 32'(mStatus));
      chk("R11 debug word", dbgWord, (mDbg & ~32'h1F0) | (32'(q.size()) << 4));
    end
  end

  task automatic pulsePush(input logic [31:0] d);
    hostWrEn = 1'b1; hostWrData = d; tick(1); hostWrEn = 1'b0;
  endtask
  task automatic pulsePop();
    hostRdEn = 1'b1; tick(1); hostRdEn = 1'b0;
  endtask
  task automatic setSize(input int s);
    blkSizeWrEn = 1'b1; blkSizeData = 12'(s); tick(1); blkSizeWrEn = 1'b0;
  endtask
  task automatic setCount(input int c);
    blkCountWrEn = 1'b1; blkCountData = 9'(c); tick(1); blkCountWrEn = 1'b0;
  endtask
  task automatic clearStatus();
    statusClrEn = 1'b1; statusClrMask = 10'h3FF; tick(1); statusClrEn = 1'b0;
  endtask
  task automatic writeDbg(input logic [31:0] d);
    dbgWrEn = 1'b1; dbgWrData = d; tick(1); dbgWrEn = 1'b0;
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R12 reset debug", dbgWord, 32'h0000C60F);
    chk("R8 reset status", 32'(statusBits), 32'h0);
    chk("R3 idle rx ready", 32'(cardRxReady), 32'h0);
    chk("R7 idle tx valid", 32'(cardTxValid), 32'h0);

    // R1 fill past capacity, drain in order; R2 empty read
    for (int i = 0; i < 17; i++) pulsePush(32'h1000 + i);
    chk("R1 level at capacity", 32'(dbgWord[8:4]), 32'd16);
    for (int i = 0; i < 16; i++) begin
      chk("R1 drain order", hostRdData, 32'h1000 + i);
      pulsePop();
    end
    chk("R2 empty data", hostRdData, 32'h0);
    pulsePop();
    chk("R2 empty level", 32'(dbgWord[8:4]), 32'd0);

    // R12 debug write rules
    writeDbg(32'h1234567F);
    chk("R12 off code stored as 0", dbgWord, 32'h12345600);
    writeDbg(32'h00000003);
    chk("R12 plain write", dbgWord, 32'h00000003);

    // R4/R5 six-byte read
    cfgDataIrqEn = 1'b1; cfgBlkIrqEn = 1'b1; xferRead = 1'b1;
    setSize(6);
    rxSrc = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    setCount(1);
    tick(15);
    chk("R11 level after read", 32'(dbgWord[8:4]), 32'd2);
    chk("R4 packed word", hostRdData, 32'h44332211);
    chk("R8 status on read", 32'(statusBits), 32'h101);
    chk("R10 data mode", 32'(dbgWord[3:0]), 32'h1);
    chk("R3 done rx ready", 32'(cardRxReady), 32'h0);
    pulsePop();
    chk("R5 partial word", hostRdData, 32'h00006655);
    pulsePop();
    clearStatus();
    chk("R8 cleared", 32'(statusBits), 32'h0);

    // R6 stall when full, then interleaved drain
    setSize(4);
    for (int i = 0; i < 80; i++) rxSrc.push_back(8'(i));
    setCount(20);
    tick(100);
    chk("R6 level full", 32'(dbgWord[8:4]), 32'd16);
    chk("R6 stalled", 32'(cardRxReady), 32'h0);
    for (int i = 0; i < 20; i++) begin
      chk("R4 long read order", hostRdData,
          {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
      pulsePop();
      tick(6);
    end
    xferRead = 1'b0;
    clearStatus();
    writeDbg(32'h0);
    chk("R12 nibble written 0", 32'(dbgWord[3:0]), 32'h0);

    // R7/R9 write of two words, data interrupt off
    cfgDataIrqEn = 1'b0; cfgBlkIrqEn = 1'b1; xferWrite = 1'b1; cardTxReady = 1'b1;
    txLog.delete();
    setCount(2);
    tick(3);
    chk("R7 empty stall", 32'(cardTxValid), 32'h0);
    pulsePush(32'hA1B2C3D4);
    pulsePush(32'h55667788);
    tick(15);
    chk("R3 byte total", 32'(txLog.size()), 32'd8);
    if (txLog.size() == 8) begin
      chk("R7 byte order", {txLog[0], txLog[1], txLog[2], txLog[3]}, 32'hD4C3B2A1);
      chk("R7 byte order", {txLog[4], txLog[5], txLog[6], txLog[7]}, 32'h88776655);
    end
    chk("R9 block flag on write", 32'(statusBits), 32'h201);
    chk("R10 data mode after write", 32'(dbgWord[3:0]), 32'h1);

    // R9 block flag disabled
    cfgBlkIrqEn = 1'b0;
    clearStatus();
    txLog.delete();
    setSize(2);
    setCount(2);
    pulsePush(32'h0A0B0C0D);
    tick(10);
    chk("R9 no block flag", 32'(statusBits), 32'h001);
    chk("R3 short write total", 32'(txLog.size()), 32'd4);
    if (txLog.size() == 4)
      chk("R7 short write order", {txLog[0], txLog[1], txLog[2], txLog[3]}, 32'h0D0C0B0A);
    xferWrite = 1'b0;
    tick(2);
    finishUp();
  end
endmodule